// File: doc/BRIEF.md
# Serial Converter Readout Emulator

This block stands in for the digital side of a two-channel, 10-bit successive-approximation converter. It serves a serial master that uses clock polarity 0 and phase 0. The master lowers an active-low select line and toggles a serial clock. The block answers on a data line that it can release, with a 16-bit result word sent most significant bit first. The sample value, the channel number, a pseudo-differential flag and two sub-LSB bits come from a stimulus register. The test environment writes that register from the system clock domain.

The level of the serial clock when select falls picks the timing mode. In the external mode the master's own clock edges move the word out. In the internal mode, the first falling clock edge starts a conversion that a local counter of system clocks times. When the count ends, the data line goes high to signal end of conversion. Both select and the serial clock pass through synchronizers into the system clock. Every output is a register.

Top module: `adc_serial_emu`

## Requirements
- R1: After reset, `dout_oe` is low and the stimulus register holds zero value, channel 0, flag clear and sub bits 00.
- R2: When select falls while the synchronized serial clock is low (external mode), the block drives `dout` low until the first serial clock fall. That fall presents the first word bit.
- R3: The word is sent MSB first as: three ones, the channel bit, the value from bit 9 down to bit 0, then sub bit 1 and sub bit 0. Each serial clock fall advances the output by one bit.
- R4: While a word is being shifted out, `dout` changes only after serial clock falls and never after rises.
- R5: After the last sub bit, further serial clock falls with select still low give zeros while `dout_oe` stays high.
- R6: `dout_oe` goes low within SYNC_STAGES+1 system clocks after select rises, and stays low while select is high.
- R7: When select falls while the serial clock is high (internal mode), `dout` is driven low. The first serial clock fall starts a conversion lasting CONV_CYC system clocks. During it `dout` stays low and serial clock falls are ignored.
- R8: At the end of the conversion `dout` goes high as the end-of-conversion flag, and this flag is the first leading one. Each later fall presents the next word bit, starting with the second one.
- R9: Raising select during a conversion abandons it and releases `dout`. A later conversion runs normally.
- R10: A select fall that comes after fewer than RECOVER_CYC system clocks of select high is ignored, and `dout_oe` stays low until select rises again.
- R11: The channel bit is 0 for channel 0 and 1 for channel 1. It is always 1 when the pseudo-differential flag is set.
- R12: A write with `stim_we` high updates the stimulus register. The word is fixed at the sampling instant: the select fall in external mode, or the first serial clock fall in internal mode. Later writes affect only the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select and shutdown line (asynchronous) |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| stim_we | input | 1 | Write strobe for the stimulus register |
| stim_value | input | DATA_W | Sample value to report |
| stim_chan | input | 1 | Channel number of the sample |
| stim_pdiff | input | 1 | Pseudo-differential flag; forces the channel bit to 1 |
| stim_sub | input | SUB_W | Sub-LSB bits appended after the value |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Output enable for `dout`; low means high impedance |

## Verification
The assertions assume that the serial clock level is steady for several system clocks around each select edge, so the mode sample is well defined. They also assume each clock phase lasts longer than the synchronizer delay, so every master edge is seen as one edge in the system domain. The stimulus holds each serial clock level for eight system clocks and moves the clock level four cycles before select changes. It samples `dout` only after the synchronizer and output register delay has passed. Internal-mode rounds leave the clock low until the conversion count has clearly expired.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CONV  = 2'd2,
    ST_SHIFT = 2'd3
  } emu_state_e;

  localparam int LEAD_ONES = 3;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= INIT;
    else     chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= INIT;
      else     chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CYCLES = 1850
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        run_q <= 1'b0;
      end else if (start) begin
        run_q <= 1'b1;
        cnt_q <= CW'(CYCLES - 1);
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign done = done_q;

  // R7: completion only follows a running count
  a_r7_done_after_run: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run_q));
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic         load_show,
  input  logic         shift,
  input  logic [W-1:0] frame_in,
  output logic         bit_out
);
  logic [W-1:0] sreg_q;
  logic         out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      out_q  <= 1'b0;
    end else if (clear) begin
      out_q <= 1'b0;
    end else if (load) begin
      sreg_q <= frame_in;
      out_q  <= 1'b0;
    end else if (load_show) begin
      sreg_q <= {frame_in[W-2:0], 1'b0};
      out_q  <= frame_in[W-1];
    end else if (shift) begin
      sreg_q <= {sreg_q[W-2:0], 1'b0};
      out_q  <= sreg_q[W-1];
    end
  end

  assign bit_out = out_q;

  // R3: one control at a time drives the shifter
  a_r3_single_ctrl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load, load_show, shift}));
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYC    = 1850,
  parameter int RECOVER_CYC = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              stim_we,
  input  logic [DATA_W-1:0] stim_value,
  input  logic              stim_chan,
  input  logic              stim_pdiff,
  input  logic [SUB_W-1:0]  stim_sub,
  output logic              dout,
  output logic              dout_oe
);
  localparam int FRAME_W = LEAD_ONES + 1 + DATA_W + SUB_W;
  localparam int RCW     = $clog2(RECOVER_CYC + 1);

  logic cs_s, sclk_s, cs_q, sclk_q;
  logic cs_fall, cs_rise, sclk_fall;

  adc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
  adc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_fall = sclk_q & ~sclk_s;

  // stimulus register
  logic [DATA_W-1:0] val_q;
  logic              id_q;
  logic [SUB_W-1:0]  sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      id_q  <= 1'b0;
      sub_q <= '0;
    end else if (stim_we) begin
      val_q <= stim_value;
      id_q  <= stim_pdiff | stim_chan;
      sub_q <= stim_sub;
    end
  end

  logic [FRAME_W-1:0] live_frame, snap_q;
  assign live_frame = {{LEAD_ONES{1'b1}}, id_q, val_q, sub_q};

  // recovery time counter
  logic [RCW-1:0] rec_cnt_q;
  logic           rec_ok;
  assign rec_ok = (rec_cnt_q == RCW'(RECOVER_CYC));

  always_ff @(posedge clk) begin
    if (rst)          rec_cnt_q <= RCW'(RECOVER_CYC);
    else if (!cs_s)   rec_cnt_q <= '0;
    else if (!rec_ok) rec_cnt_q <= rec_cnt_q + 1'b1;
  end

  // control
  emu_state_e st_q, st_d;
  logic do_clear, do_load, do_show, do_shift, t_start, t_abort, t_done, snap_en;

  always_comb begin
    st_d     = st_q;
    do_clear = 1'b0;
    do_load  = 1'b0;
    do_show  = 1'b0;
    do_shift = 1'b0;
    t_start  = 1'b0;
    t_abort  = 1'b0;
    snap_en  = 1'b0;
    if (cs_rise) begin
      st_d     = ST_IDLE;
      do_clear = 1'b1;
      t_abort  = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          do_clear = 1'b1;
          if (cs_fall && rec_ok) begin
            if (sclk_s) begin
              st_d = ST_WAIT;
            end else begin
              do_clear = 1'b0;
              do_load  = 1'b1;
              st_d     = ST_SHIFT;
            end
          end
        end
        ST_WAIT: begin
          if (sclk_fall) begin
            t_start = 1'b1;
            snap_en = 1'b1;
            st_d    = ST_CONV;
          end
        end
        ST_CONV: begin
          if (t_done) begin
            do_show = 1'b1;
            st_d    = ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (sclk_fall) do_shift = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      oe_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      st_q <= st_d;
      oe_q <= (st_d != ST_IDLE);
      if (snap_en) snap_q <= live_frame;
    end
  end

  adc_conv_timer #(.CYCLES(CONV_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .abort(t_abort), .done(t_done));

  adc_frame_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .clear(do_clear), .load(do_load), .load_show(do_show),
    .shift(do_shift), .frame_in(do_show ? snap_q : live_frame), .bit_out(dout));

  assign dout_oe = oe_q;

  // R6: select high releases the line on the next edge
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !dout_oe);

  // R4: no output change in shifting without a serial clock fall
  a_r4_fall_only: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SHIFT && $past(st_q) == ST_SHIFT && !$past(sclk_fall)) |-> $stable(dout));

  // R7: line held low and driven during conversion
  a_r7_conv_low: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CONV) |-> (dout_oe && !dout));

  // R8: end of conversion raises the line
  a_r8_eoc_high: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CONV && t_done && !cs_rise) |=> (dout && dout_oe));

  // R10: early select fall is ignored
  a_r10_recover: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && cs_fall && !rec_ok) |=> !dout_oe);
endmodule

// File: tb/adc_serial_emu_tb.sv
module adc_serial_emu_tb;
  localparam int CONV = 1850;

  typedef struct {
    logic  oe;
    logic  d;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       stim_we = 1'b0;
  logic [9:0] stim_value = '0;
  logic       stim_chan = 1'b0;
  logic       stim_pdiff = 1'b0;
  logic [1:0] stim_sub = '0;
  logic       dout, dout_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  exp_t q[$];
  event smp_ev;

  always #2 clk = ~clk;

  adc_serial_emu #(.CONV_CYC(CONV)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .stim_we(stim_we),
    .stim_value(stim_value), .stim_chan(stim_chan), .stim_pdiff(stim_pdiff),
    .stim_sub(stim_sub), .dout(dout), .dout_oe(dout_oe));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input logic oe, input logic d, input string req);
    exp_t e;
    e.oe = oe; e.d = d; e.req = req;
    q.push_back(e);
    ->smp_ev;
    @(negedge clk);
  endtask

  // monitor: pops expectations and compares at the sample point
  initial begin
    forever begin
      @(smp_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (dout_oe !== e.oe || (e.oe && dout !== e.d)) begin
          errors++;
          $display("FAIL %s: oe=%b dout=%b expected oe=%b dout=%b",
                   e.req, dout_oe, dout, e.oe, e.d);
        end
      end
    end
  end

  function automatic logic [15:0] mk(input logic [9:0] v, input logic ch,
                                     input logic pd, input logic [1:0] s);
    return {3'b111, ch | pd, v, s};
  endfunction

  task automatic load_stim(input logic [9:0] v, input logic ch,
                           input logic pd, input logic [1:0] s);
    @(negedge clk);
    stim_we = 1'b1; stim_value = v; stim_chan = ch; stim_pdiff = pd; stim_sub = s;
    @(negedge clk);
    stim_we = 1'b0;
  endtask

  task automatic end_frame();
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_clk(8);
    expect_now(1'b0, 1'b0, "R6");
    wait_clk(20);
  endtask

  task automatic ext_frame(input logic [15:0] fr, input int nz, input bit chg);
    logic prev;
    sclk = 1'b0;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(8);
    expect_now(1'b1, 1'b0, "R2");
    prev = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b1;
      wait_clk(8);
      expect_now(1'b1, prev, "R4");
      sclk = 1'b0;
      wait_clk(8);
      expect_now(1'b1, fr[i], (i == 15) ? "R2" : "R3");
      prev = fr[i];
      if (chg && i == 10) load_stim(10'h30F, 1'b1, 1'b0, 2'b11); // R12
    end
    for (int k = 0; k < nz; k++) begin
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(8);
      expect_now(1'b1, 1'b0, "R5");
    end
    end_frame();
  endtask

  task automatic int_frame(input logic [15:0] fr, input bit chg);
    sclk = 1'b1;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(8);
    expect_now(1'b1, 1'b0, "R7");
    sclk = 1'b0;
    wait_clk(CONV / 2);
    expect_now(1'b1, 1'b0, "R7");
    if (chg) load_stim(10'h000, 1'b0, 1'b0, 2'b00); // R12 after sampling instant
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
    wait_clk(8);
    expect_now(1'b1, 1'b0, "R7");
    wait_clk(CONV / 2 + 20);
    expect_now(1'b1, 1'b1, "R8");
    for (int i = 14; i >= 0; i--) begin
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(8);
      expect_now(1'b1, fr[i], (i == 14) ? "R8" : "R3");
    end
    for (int k = 0; k < 2; k++) begin
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
      wait_clk(8);
      expect_now(1'b1, 1'b0, "R5");
    end
    end_frame();
  endtask

  initial begin
    wait_clk(10);
    rst = 1'b0;
    wait_clk(4);
    expect_now(1'b0, 1'b0, "R1");

    // R1: cleared stimulus gives an all-zero value with channel 0
    ext_frame(mk(10'h000, 1'b0, 1'b0, 2'b00), 0, 1'b0);

    load_stim(10'h2A5, 1'b0, 1'b0, 2'b10);
    ext_frame(mk(10'h2A5, 1'b0, 1'b0, 2'b10), 3, 1'b0);   // R3 R5

    load_stim(10'h15A, 1'b1, 1'b0, 2'b01);
    ext_frame(mk(10'h15A, 1'b1, 1'b0, 2'b01), 1, 1'b0);   // R11 channel 1

    load_stim(10'h3FF, 1'b0, 1'b1, 2'b11);
    ext_frame(mk(10'h3FF, 1'b0, 1'b1, 2'b11), 0, 1'b0);   // R11 pseudo-differential

    load_stim(10'h0F0, 1'b0, 1'b0, 2'b00);
    ext_frame(mk(10'h0F0, 1'b0, 1'b0, 2'b00), 0, 1'b1);   // R12 mid-frame write ignored
    ext_frame(mk(10'h30F, 1'b1, 1'b0, 2'b11), 0, 1'b0);   // R12 write used next

    load_stim(10'h1C3, 1'b1, 1'b0, 2'b10);
    int_frame(mk(10'h1C3, 1'b1, 1'b0, 2'b10), 1'b1);      // R7 R8 R12

    // R9: abort during conversion
    load_stim(10'h255, 1'b0, 1'b0, 2'b01);
    sclk = 1'b1;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(8);
    sclk = 1'b0;
    wait_clk(50);
    cs_n = 1'b1;
    wait_clk(8);
    expect_now(1'b0, 1'b0, "R9");
    wait_clk(CONV + 20);
    expect_now(1'b0, 1'b0, "R9");
    ext_frame(mk(10'h255, 1'b0, 1'b0, 2'b01), 0, 1'b0);   // R9 next conversion

    // R10: short select-high time
    sclk = 1'b0;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(5);
    cs_n = 1'b0;
    wait_clk(8);
    expect_now(1'b0, 1'b0, "R10");
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
    wait_clk(8);
    expect_now(1'b0, 1'b0, "R10");
    end_frame();
    ext_frame(mk(10'h255, 1'b0, 1'b0, 2'b01), 0, 1'b0);   // R10 recovered

    wait_clk(4);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule